// File: doc/BRIEF.md
# SD Data Line Timeout Counter

This block decides when a card has gone quiet for too long during a data phase. It counts card clock periods while a wait is in progress. When the count reaches a programmable interval it raises a one-cycle timeout pulse and sets a sticky status bit. The interval is a power of two, picked by a 4-bit exponent code that is added to a base exponent. The smallest interval is 2^13 card clock periods and the largest is 2^27.

The block runs on the system clock. A one-cycle `cardTick` strobe marks each card clock period, so only periods with a tick are counted. Each data event sends a `restart` strobe, which zeroes the count and arms the counter. A `waitActive` level gates the counting.

The status enable gates both the pulse and the sticky bit. Software clears the enable while it rewrites the code, so that a smaller interval cannot raise a spurious timeout. Software clears the sticky bit with a write-one-to-clear strobe.

Top module: `sd_tout_top`

## Requirements
- R1: After reset, `timeoutPulse` and `timeoutStatus` are 0. The counter stays disarmed until the first `restart`.
- R2: For codes 0 to 14, the timeout occurs on the 2^(BASE_EXP+code) counted card tick after a restart. BASE_EXP defaults to 13.
- R3: Code 15 is reserved. It gives the same interval as code 14 and drives `codeIllegal` high. For every other code, `codeIllegal` is 0.
- R4: A system clock cycle is counted only when `cardTick` and `waitActive` are both 1. Any other cycle leaves the count unchanged.
- R5: `restart` zeroes the count and arms the counter. A tick in the same cycle as `restart` is not counted.
- R6: When statuses are enabled, `timeoutPulse` is 1 for exactly one cycle, in the cycle after the final counted tick. `timeoutStatus` becomes 1 in that same cycle.
- R7: After a timeout, the counter stops. No further pulse occurs until the next `restart`.
- R8: While `statusEn` is 0 in the cycle of the final tick, no pulse is produced and the status bit is not set. The counter still stops.
- R9: `clearStatus` clears `timeoutStatus` to 0 in the next cycle. If a timeout sets the bit in that same cycle, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cardTick | input | 1 | One-cycle strobe per card clock period |
| toutCode | input | 4 | Interval exponent code; 15 is reserved |
| restart | input | 1 | Data event strobe: zero the count and arm |
| waitActive | input | 1 | High while waiting for data activity |
| statusEn | input | 1 | Enables the timeout pulse and status |
| clearStatus | input | 1 | Write-one-to-clear strobe for the status bit |
| timeoutPulse | output | 1 | One-cycle timeout indication |
| timeoutStatus | output | 1 | Sticky timeout status bit |
| codeIllegal | output | 1 | High while the reserved code is selected |

## Verification
The bench runs with a small base exponent so that every code can be reached in a short run.

Random runs draw a code and random tick and wait densities. They check that the pulse lands on the exact counted tick and never earlier. This tells true counting of qualified ticks apart from counting of system clock cycles.

Directed cases cover the following:
- a restart just before expiry, which must reset the count;
- a restart that carries a tick;
- expiry with the enable low;
- a clear that coincides with a timeout;
- the reserved code against code 14, which tells clamping apart from wrap-around of the exponent.

// File: rtl/sd_tout_pkg.sv
package sd_tout_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
  } toutCtl_t;
endpackage

// File: rtl/sd_tout_datapath.sv
module sd_tout_datapath
  import sd_tout_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  toutCtl_t          ctl,
  input  logic [CODE_W-1:0] toutCode,
  output logic              atLimit,
  output logic              codeIllegal
);
  localparam int MAX_CODE = (1 << CODE_W) - 2;
  localparam int CNT_W    = BASE_EXP + MAX_CODE + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limitM1;
  logic [CODE_W-1:0] effCode;

  always_comb begin
    codeIllegal = (toutCode == {CODE_W{1'b1}});
    effCode     = codeIllegal ? CODE_W'(MAX_CODE) : toutCode;
    limitM1     = (CNT_W'(1) << (BASE_EXP + int'(effCode))) - CNT_W'(1);
    // >= keeps a lowered code from letting the count run past the limit
    atLimit     = (cnt >= limitM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (ctl.clearCnt) cnt <= '0;
    else if (ctl.incCnt)   cnt <= cnt + CNT_W'(1);
  end

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearCnt |=> (cnt == '0));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clearCnt && !ctl.incCnt) |=> $stable(cnt));
endmodule

// File: rtl/sd_tout_ctrl.sv
module sd_tout_ctrl
  import sd_tout_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cardTick,
  input  logic     restart,
  input  logic     waitActive,
  input  logic     statusEn,
  input  logic     clearStatus,
  input  logic     atLimit,
  output toutCtl_t ctl,
  output logic     timeoutPulse,
  output logic     timeoutStatus
);
  logic armed;
  logic hit;

  always_comb begin
    ctl.clearCnt = restart;
    ctl.incCnt   = armed && waitActive && cardTick && !restart;
    hit          = ctl.incCnt && atLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed         <= 1'b0;
      timeoutPulse  <= 1'b0;
      timeoutStatus <= 1'b0;
    end else begin
      if (restart)  armed <= 1'b1;
      else if (hit) armed <= 1'b0;
      timeoutPulse  <= hit && statusEn;
      timeoutStatus <= (hit && statusEn) || (timeoutStatus && !clearStatus);
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  // R8
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(statusEn));
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutStatus && !clearStatus) |=> timeoutStatus);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> timeoutStatus);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !timeoutPulse);
endmodule

// File: rtl/sd_tout_top.sv
module sd_tout_top
  import sd_tout_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cardTick,
  input  logic [CODE_W-1:0] toutCode,
  input  logic              restart,
  input  logic              waitActive,
  input  logic              statusEn,
  input  logic              clearStatus,
  output logic              timeoutPulse,
  output logic              timeoutStatus,
  output logic              codeIllegal
);
  toutCtl_t ctl;
  logic     atLimit;

  sd_tout_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cardTick(cardTick), .restart(restart),
    .waitActive(waitActive), .statusEn(statusEn), .clearStatus(clearStatus),
    .atLimit(atLimit), .ctl(ctl), .timeoutPulse(timeoutPulse),
    .timeoutStatus(timeoutStatus)
  );

  sd_tout_datapath #(.BASE_EXP(BASE_EXP), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .toutCode(toutCode),
    .atLimit(atLimit), .codeIllegal(codeIllegal)
  );
endmodule

// File: tb/sd_tout_top_test.sv
module sd_tout_top_test;
  localparam int BASE_EXP = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cardTick, restart, waitActive, statusEn, clearStatus;
  logic [3:0] toutCode;
  logic       timeoutPulse, timeoutStatus, codeIllegal;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  sd_tout_top #(.BASE_EXP(BASE_EXP), .CODE_W(4)) uut (
    .clk(clk), .rstN(rstN), .cardTick(cardTick), .toutCode(toutCode),
    .restart(restart), .waitActive(waitActive), .statusEn(statusEn),
    .clearStatus(clearStatus), .timeoutPulse(timeoutPulse),
    .timeoutStatus(timeoutStatus), .codeIllegal(codeIllegal)
  );

  function automatic int expTicks(input logic [3:0] code);
    int e;
    e = (code == 4'hF) ? 14 : int'(code);
    return 1 << (BASE_EXP + e);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idleIn();
    cardTick = 0; restart = 0; waitActive = 0; clearStatus = 0;
  endtask

  // R5: restart strobe, possibly with a tick that must not count
  task automatic doRestart(input logic withTick);
    @(negedge clk);
    idleIn();
    restart = 1; cardTick = withTick; waitActive = 1;
  endtask

  // Feed n counted ticks (random gaps); returns with the last tick driven.
  // Checks that no pulse appears before that.
  task automatic feed(input int n, input int tickPct, input int waitPct,
                      input logic clrOnLast, input string req);
    int counted = 0;
    while (counted < n) begin
      @(negedge clk);
      check(req, int'(timeoutPulse), 0);
      idleIn();
      cardTick   = (($urandom % 100) < tickPct);
      waitActive = (($urandom % 100) < waitPct);
      if (cardTick && waitActive) begin
        counted++;
        if (counted == n) clearStatus = clrOnLast;
      end
    end
  endtask

  task automatic expectTimeout(input int en, input int stat, input string req);
    @(negedge clk);
    check(req, int'(timeoutPulse), en);
    check(req, int'(timeoutStatus), stat);
    idleIn();
    cardTick = 1; waitActive = 1;
    // R7: stopped; further ticks never pulse
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7", int'(timeoutPulse), 0);
    end
    idleIn();
  endtask

  task automatic clearIt();
    @(negedge clk);
    idleIn(); clearStatus = 1;
    @(negedge clk);
    idleIn();
    check("R9", int'(timeoutStatus), 0);
  endtask

  initial begin
    int seen;
    for (seen = 0; seen < 195000; seen++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", seen);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    idleIn(); toutCode = 0; statusEn = 1; rstN = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(timeoutPulse), 0);
    check("R1", int'(timeoutStatus), 0);
    rstN = 1;
    // R1: disarmed until first restart
    cardTick = 1; waitActive = 1;
    repeat (20) @(negedge clk);
    check("R1", int'(timeoutPulse), 0);
    check("R1", int'(timeoutStatus), 0);
    idleIn();

    // R2/R4/R5/R6: random codes and densities
    for (int it = 0; it < 20; it++) begin
      logic [3:0] c;
      c = 4'($urandom % 7);
      toutCode = c;
      doRestart(1'($urandom % 2));
      feed(expTicks(c), 30 + int'($urandom % 71), 40 + int'($urandom % 61), 1'b0, "R2");
      expectTimeout(1, 1, "R6");
      check("R3", int'(codeIllegal), 0);
      clearIt();
    end

    // R5: restart just before expiry resets the count
    toutCode = 4'd3;
    doRestart(1'b0);
    feed(expTicks(4'd3) - 1, 100, 100, 1'b0, "R5");
    doRestart(1'b1);
    feed(expTicks(4'd3), 100, 100, 1'b0, "R5");
    expectTimeout(1, 1, "R5");

    // R9: clear coinciding with timeout leaves status set
    doRestart(1'b0);
    feed(expTicks(4'd3), 100, 100, 1'b1, "R9");
    expectTimeout(1, 1, "R9");
    clearIt();

    // R8: enable low, no pulse or status, counter stops
    statusEn = 0;
    toutCode = 4'd5;
    doRestart(1'b0);
    feed(expTicks(4'd5), 80, 90, 1'b0, "R8");
    expectTimeout(0, 0, "R8");
    statusEn = 1;
    doRestart(1'b0);
    feed(expTicks(4'd5), 80, 90, 1'b0, "R8");
    expectTimeout(1, 1, "R8");
    clearIt();

    // R3 / R2: code 14 and reserved code 15 give the same interval
    toutCode = 4'd14;
    @(negedge clk);
    check("R3", int'(codeIllegal), 0);
    doRestart(1'b0);
    feed(expTicks(4'd14), 100, 100, 1'b0, "R2");
    expectTimeout(1, 1, "R2");
    clearIt();
    toutCode = 4'd15;
    @(negedge clk);
    check("R3", int'(codeIllegal), 1);
    doRestart(1'b0);
    feed(expTicks(4'd15), 100, 100, 1'b0, "R3");
    expectTimeout(1, 1, "R3");
    clearIt();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule